// File: doc/BRIEF.md
# Cascadable Serial-Load Latched Channel Driver

This block takes a bit stream on one serial pin and clocks it into a chain of shift stages. On a separate register clock it copies the whole chain into a holding register, and that register drives one on/off control line per power channel. Changing the load pattern therefore never glitches the channels while new data is shifting in. An active-low output enable can turn every channel off without touching stored data. An active-low clear empties both the shift stages and the holding register.

The last shift stage is also presented on a cascade output. That output is relaunched on the falling shift-clock edge, half a period after the stages move. The next device in a chain then samples a value that has been stable for half a clock, which tolerates clock skew between distant devices. With two devices chained, 2×WIDTH shift clocks followed by one register-clock pulse load both devices at once.

Top module: `sipo_latch_driver`

## Requirements
- R1: On each rising edge of `shiftClk`, `serIn` enters stage 0 and every stage k moves to stage k+1. After one shift of a 1 into a cleared block and one latch pulse, `driveOn` reads 8'h01. After three more shifts of 0, `driveOn` reads 8'h08.
- R2: A rising edge of `latchClk` copies all WIDTH shift stages into the holding register at once. Rising edges of `shiftClk` leave the holding register, and therefore `driveOn`, unchanged.
- R3: While `clearN` is low, the shift stages, the holding register and the cascade flop are all forced to zero at once, without any clock edge. After `clearN` returns high, a latch pulse with no shifts in between gives `driveOn` = 0.
- R4: While `outEnN` is high, `driveOn` is all zero. While `outEnN` is low, bit i of `driveOn` equals holding bit i, where 1 means the channel is on (sinking) and 0 means off. Toggling `outEnN` does not alter the stored data.
- R5: `serOut` equals the last shift stage but changes only on the falling edge of `shiftClk`. Between a rising edge and the following falling edge, it still shows the stage value from before that rising edge.
- R6: With `serOut` of a first device feeding `serIn` of a second, send bits w[0] first through w[15] last and then give one latch pulse. The first device's channel k then holds w[15-k], and the second device's channel k holds w[7-k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock; stages move on its rising edge |
| latchClk | input | 1 | Register clock; holding register loads on its rising edge |
| clearN | input | 1 | Active-low asynchronous clear of every register |
| outEnN | input | 1 | Active-low output enable; high forces all channels off |
| serIn | input | 1 | Serial data input to stage 0 |
| driveOn | output | WIDTH (8) | Per-channel on command, 1 = channel sinking |
| serOut | output | 1 | Cascade output, last stage relaunched on falling `shiftClk` |

## Verification
A shift stage that picks up the wrong bit appears on `serOut` once that bit reaches the last stage, at a falling edge. It also appears on `driveOn` at the next latch pulse, so a chained pair exposes it within 2×WIDTH shifts. A holding register that follows the shift stages shows as `driveOn` moving during a shift burst. A cascade flop clocked on the wrong edge shows as `serOut` changing in the half period right after a rising edge. A clear that misses any register shows as a nonzero `driveOn` or `serOut` after the clear and one latch pulse.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // active-high clear of all storage
    logic driveGate;  // 1 = channels may follow holding register
  } sldStrobe_t;
endpackage

// File: rtl/sld_ctrl.sv
module sld_ctrl
  import sld_pkg::*;
(
  input  logic       clearN,
  input  logic       outEnN,
  output sldStrobe_t strb
);
  always_comb begin
    strb.clrAll    = ~clearN;
    strb.driveGate = ~outEnN;
  end
endmodule

// File: rtl/sld_datapath.sv
module sld_datapath
  import sld_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             serIn,
  input  sldStrobe_t       strb,
  output logic [WIDTH-1:0] driveOn,
  output logic             serOut
);
  localparam int LAST = WIDTH - 1;

  logic             clrAll;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;
  logic             serOutQ;

  assign clrAll = strb.clrAll;

  // shift chain: stage 0 takes serial input
  always_ff @(posedge shiftClk or posedge clrAll) begin
    if (clrAll) shiftQ <= '0;
    else        shiftQ <= {shiftQ[LAST-1:0], serIn};
  end

  // holding register, parallel load
  always_ff @(posedge latchClk or posedge clrAll) begin
    if (clrAll) storeQ <= '0;
    else        storeQ <= shiftQ;
  end

  // cascade flop relaunches last stage on falling edge
  always_ff @(negedge shiftClk or posedge clrAll) begin
    if (clrAll) serOutQ <= 1'b0;
    else        serOutQ <= shiftQ[LAST];
  end

  assign serOut = serOutQ;

  // per-channel output gating
  for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
    assign driveOn[ch] = strb.driveGate & storeQ[ch];
  end

  // R1: stages advance by one per rising shift edge
  a_r1_shift_advance: assert property (@(posedge shiftClk) disable iff (clrAll)
    1'b1 |=> (shiftQ == {$past(shiftQ[LAST-1:0]), $past(serIn)}));

  // R2: holding register matches shift chain after a latch edge (shift idle)
  a_r2_parallel_load: assert property (@(negedge latchClk) disable iff (clrAll)
    1'b1 |-> (storeQ == shiftQ));

  // R3: clear empties every register
  a_r3_clear_all: assert property (@(posedge latchClk)
    clrAll |-> (storeQ == '0 && shiftQ == '0 && serOutQ == 1'b0));

  // R5: cascade output follows last stage one falling edge later
  a_r5_fall_launch: assert property (@(negedge shiftClk) disable iff (clrAll)
    1'b1 |=> (serOutQ == $past(shiftQ[LAST])));
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver
  import sld_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             clearN,
  input  logic             outEnN,
  input  logic             serIn,
  output logic [WIDTH-1:0] driveOn,
  output logic             serOut
);
  sldStrobe_t strb;

  sld_ctrl u_ctrl (
    .clearN (clearN),
    .outEnN (outEnN),
    .strb   (strb)
  );

  sld_datapath #(.WIDTH(WIDTH)) u_dp (
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .serIn    (serIn),
    .strb     (strb),
    .driveOn  (driveOn),
    .serOut   (serOut)
  );

  // R4: disabled outputs are all off
  a_r4_enable_off: assert property (@(posedge latchClk) disable iff (!clearN)
    outEnN |-> (driveOn == '0));
endmodule

// File: tb/sipo_latch_driver_bench.sv
module sipo_latch_driver_bench;
  localparam int CLK_PERIOD = 100;
  localparam int Q = CLK_PERIOD / 4;
  localparam int W = 8;

  logic shiftClk = 1'b0, latchClk = 1'b0, clearN = 1'b1, outEnN = 1'b1, serIn = 1'b0;
  logic [W-1:0] driveA, driveB;
  logic serA, serB;

  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  // bench model of requirement behaviour
  logic [W-1:0] mA = '0, mB = '0, sA = '0, sB = '0;
  logic mSerA = 1'b0, mSerB = 1'b0;

  sipo_latch_driver #(.WIDTH(W)) u_sipo_latch_driver (
    .shiftClk(shiftClk), .latchClk(latchClk), .clearN(clearN), .outEnN(outEnN),
    .serIn(serIn), .driveOn(driveA), .serOut(serA));

  sipo_latch_driver #(.WIDTH(W)) u_sipo_latch_driver_b (
    .shiftClk(shiftClk), .latchClk(latchClk), .clearN(clearN), .outEnN(outEnN),
    .serIn(serA), .driveOn(driveB), .serOut(serB));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] gated(input logic [W-1:0] s);
    return outEnN ? '0 : s;
  endfunction

  // R6: expected byte per device from a 16-bit word, w[0] sent first
  function automatic logic [W-1:0] expectByte(input logic [15:0] w, input bit far);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = far ? w[7-k] : w[15-k];
    return r;
  endfunction

  task automatic shiftBit(input logic b);
    logic oldSerA;
    serIn = b;
    #Q;
    shiftClk = 1'b1;
    oldSerA = mSerA;
    mB = {mB[W-2:0], mSerA};
    mA = {mA[W-2:0], b};
    #Q;
    chk("R5 serOut holds before fall", {{(W-1){1'b0}}, serA}, {{(W-1){1'b0}}, oldSerA});
    chk("R2 hold during shift", driveA, gated(sA));
    shiftClk = 1'b0;
    mSerA = mA[W-1];
    mSerB = mB[W-1];
    #Q;
    chk("R5 serOut after fall", {{(W-1){1'b0}}, serA}, {{(W-1){1'b0}}, mSerA});
    #Q;
  endtask

  task automatic latchPulse();
    #Q; latchClk = 1'b1; sA = mA; sB = mB;
    #Q; latchClk = 1'b0;
    #Q;
  endtask

  task automatic doClear();
    clearN = 1'b0;
    mA = '0; mB = '0; sA = '0; sB = '0; mSerA = 1'b0; mSerB = 1'b0;
    #Q;
    chk("R3 async clear A", driveA, '0);
    chk("R3 async clear B", driveB, '0);
    chk("R3 serOut cleared", {{(W-1){1'b0}}, serA}, '0);
    // clock edges while held in clear
    shiftClk = 1'b1; #Q; shiftClk = 1'b0; #Q;
    latchClk = 1'b1; #Q; latchClk = 1'b0; #Q;
    clearN = 1'b1;
    #Q;
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 0; i < 16; i++) shiftBit(w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [15:0] w;
    seedDummy = $urandom(32'd4242);
    #1;
    doClear();
    outEnN = 1'b0;
    #Q;
    chk("R3 reset state A", driveA, '0);
    chk("R3 reset state B", driveB, '0);

    // R1 directed
    shiftBit(1'b1); latchPulse();
    chk("R1 first bit at stage 0", driveA, 8'h01);
    chk("R1 far device empty", driveB, 8'h00);
    repeat (3) shiftBit(1'b0);
    latchPulse();
    chk("R1 bit moved to stage 3", driveA, 8'h08);

    // R6 directed patterns
    doClear();
    sendWord(16'hFFFF); latchPulse();
    chk("R6 all ones near", driveA, expectByte(16'hFFFF, 1'b0));
    chk("R6 all ones far", driveB, expectByte(16'hFFFF, 1'b1));
    sendWord(16'h5A3C); latchPulse();
    chk("R6 pattern near", driveA, expectByte(16'h5A3C, 1'b0));
    chk("R6 pattern far", driveB, expectByte(16'h5A3C, 1'b1));

    // R4 enable gating without data loss
    outEnN = 1'b1; #Q;
    chk("R4 disabled near off", driveA, '0);
    chk("R4 disabled far off", driveB, '0);
    outEnN = 1'b0; #Q;
    chk("R4 re-enabled near", driveA, expectByte(16'h5A3C, 1'b0));
    chk("R4 re-enabled far", driveB, expectByte(16'h5A3C, 1'b1));

    // R3 clear mid-shift, then latch with no shifts
    repeat (5) shiftBit(1'b1);
    doClear();
    latchPulse();
    chk("R3 latch after clear near", driveA, '0);
    chk("R3 latch after clear far", driveB, '0);

    // random words, random enable, random clears
    for (int r = 0; r < 40; r++) begin
      w = 16'($urandom);
      outEnN = 1'($urandom % 4 == 0);
      if ($urandom % 8 == 0) doClear();
      sendWord(w);
      latchPulse();
      chk("R6 random near", driveA, outEnN ? '0 : expectByte(w, 1'b0));
      chk("R6 random far", driveB, outEnN ? '0 : expectByte(w, 1'b1));
      chk("R2 model near", driveA, gated(sA));
      chk("R4 far gated", driveB, gated(sB));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule